// File: doc/BRIEF.md
# Binary128 to Unsigned 64-bit Integer Converter

This unit takes a 128-bit IEEE binary128 operand and returns its value as a 64-bit unsigned integer, along with an invalid flag and an inexact flag. The operand is split into its fields and the hidden bit is restored. The 113-bit significand is then placed on a fixed-point grid with 64 integer bits and 64 fraction bits. A left shift is used for large exponents. For small exponents a right shift is used, and every bit pushed off the bottom is folded into the lowest fraction bit as a sticky bit. The aligned value is rounded by a 2-bit mode selector. A per-operation truncation strobe overrides that selector for one conversion and leaves it untouched.

Out-of-range values saturate to all ones. NaNs always give all ones. Negative values never produce a nonzero result: magnitudes of at least one raise invalid, and smaller negative values raise inexact only when rounding would have produced a magnitude of one.

The result is held in a single output register. A two-state slot machine tracks whether that register holds a fresh result. State `ST_EMPTY` moves to `ST_FULL` on a load (`in_valid` high). `ST_FULL` stays in `ST_FULL` when results stream back-to-back, and drains to `ST_EMPTY` when `in_valid` is low. `ST_EMPTY` stays idle while nothing arrives.

Top module: `q2u_convert`

## Requirements
- R1: A result and its flags appear on the outputs, with `out_valid` high, exactly one clock after the cycle in which `in_valid` is high. `out_valid` is low after any cycle without `in_valid`. Reset clears `out_valid`, the result and both flags to zero.
- R2: The operand fields are sign at bit 127, biased exponent at bits 126:112 (bias 16383) and fraction at bits 111:0. Positive integers from 1 to 2^64-1 convert exactly with both flags low.
- R3: `round_mode` selects the rounding: 00 is nearest with ties to even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity.
- R4: A positive in-range conversion that is not saturated raises inexact exactly when the discarded fraction is nonzero, and never raises invalid.
- R5: When `trunc_force` is high, the conversion truncates no matter what `round_mode` holds. The mode applied to the following conversions stays the one on `round_mode`.
- R6: If rounding a positive value carries beyond 2^64-1, the result is all ones with invalid high and inexact low.
- R7: Any NaN (exponent all ones, fraction nonzero, either sign), +infinity and any positive value of 2^64 or more give all ones with invalid high and inexact low.
- R8: A negative non-NaN operand of magnitude at least 1.0, including -infinity, gives zero with invalid high and inexact low.
- R9: A negative operand of magnitude below 1.0 gives zero with invalid low. Inexact is high only if the effective mode would round the magnitude up to one.
- R10: Zero of either sign gives zero with no flags. A positive subnormal raises inexact and gives zero, except under rounding toward +infinity where it gives one.
- R11: Fraction bits lying further than 64 places below the binary point still count as nonzero for rounding and inexact. For example, 2.5 plus 2^-111 rounds to 3 under nearest-even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 128 | binary128 operand |
| round_mode | input | 2 | Rounding mode selector |
| trunc_force | input | 1 | Truncate this conversion regardless of mode |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Unsigned integer result |
| flag_invalid | output | 1 | Invalid operation flag |
| flag_inexact | output | 1 | Inexact result flag |

## Verification
Rounding increment and saturation can coincide in one conversion. The operand 2^64-0.5 has an integer part that is already all ones and a fraction of exactly one half. Under nearest-even, the tie goes to the odd integer part, the increment carries out, and the result must be all ones with only invalid raised. The same operand is then sent back-to-back under toward-zero and under the truncation strobe, and each of these must give all ones with only inexact raised. The scoreboard computes every expected value with a wide fixed-point model and pairs it with the design's output in order.

// File: rtl/q2u_pkg.sv
package q2u_pkg;
    localparam int unsigned OP_W      = 128;
    localparam int unsigned EXP_W     = 15;
    localparam int unsigned FRAC_W    = 112;
    localparam int unsigned RES_W     = 64;
    localparam int unsigned SIG_W     = FRAC_W + 1;
    localparam int unsigned ALN_W     = 2 * RES_W;
    localparam int unsigned BIAS      = (1 << (EXP_W - 1)) - 1;
    // exponent at which the significand LSB sits at weight 2^-RES_W
    localparam int unsigned ALIGN_REF = BIAS + FRAC_W - RES_W;
    // largest exponent whose value still fits in RES_W bits
    localparam int unsigned SAT_EXP   = BIAS + RES_W - 1;
    // largest exponent with magnitude below one
    localparam int unsigned NEG_EXP   = BIAS - 1;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } quad_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_e;
endpackage

// File: rtl/q2u_unpack.sv
module q2u_unpack
    import q2u_pkg::*;
(
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [ALN_W-1:0]  sig_o,
    output logic              is_nan_o
);
    logic hidden;

    assign hidden   = |exp_i;
    assign sig_o    = {{(ALN_W - SIG_W){1'b0}}, hidden, frac_i};
    assign is_nan_o = (&exp_i) && (|frac_i);
endmodule

// File: rtl/q2u_align.sv
module q2u_align
    import q2u_pkg::*;
(
    input  logic [EXP_W-1:0] exp_i,
    input  logic [ALN_W-1:0] sig_i,
    output logic [ALN_W-1:0] aligned_o
);
    localparam int unsigned CNT_W = EXP_W + 2;

    logic signed [CNT_W-1:0] shamt;
    logic [CNT_W-1:0]        rcnt;
    logic [CNT_W-1:0]        lcnt;
    logic [ALN_W-1:0]        kept;
    logic [ALN_W-1:0]        spill;

    assign shamt = $signed(CNT_W'(ALIGN_REF)) - $signed({2'b00, exp_i});
    assign rcnt  = shamt;
    assign lcnt  = -shamt;

    always_comb begin
        kept  = sig_i >> rcnt;
        spill = sig_i << (CNT_W'(ALN_W) - rcnt);
        if (shamt[CNT_W-1] || (shamt == '0)) begin
            aligned_o = sig_i << lcnt;
        end else if (rcnt >= CNT_W'(ALN_W)) begin
            aligned_o = {{(ALN_W - 1){1'b0}}, |sig_i};
        end else begin
            aligned_o = {kept[ALN_W-1:1], kept[0] | (|spill)};
        end
    end
endmodule

// File: rtl/q2u_round.sv
module q2u_round
    import q2u_pkg::*;
(
    input  logic             sign_i,
    input  logic [ALN_W-1:0] aligned_i,
    input  rmode_e           mode_i,
    output logic [RES_W-1:0] mag_o,
    output logic             carry_o,
    output logic             frac_nz_o,
    output logic             bump_o
);
    logic [RES_W-1:0] int_part;
    logic [RES_W-1:0] frc;
    logic             half;
    logic             below;

    assign int_part  = aligned_i[ALN_W-1:RES_W];
    assign frc       = aligned_i[RES_W-1:0];
    assign half      = frc[RES_W-1];
    assign below     = |frc[RES_W-2:0];
    assign frac_nz_o = |frc;

    always_comb begin
        unique case (mode_i)
            RM_NEAR_EVEN: bump_o = half && (below || int_part[0]);
            RM_TO_ZERO:   bump_o = 1'b0;
            RM_TO_POS:    bump_o = !sign_i && frac_nz_o;
            RM_TO_NEG:    bump_o = sign_i && frac_nz_o;
        endcase
    end

    assign {carry_o, mag_o} = {1'b0, int_part} + (RES_W + 1)'(bump_o);
endmodule

// File: rtl/q2u_convert.sv
module q2u_convert
    import q2u_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  operand,
    input  logic [1:0]       round_mode,
    input  logic             trunc_force,
    output logic             out_valid,
    output logic [RES_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact
);
    quad_t            op;
    rmode_e           eff_mode;
    logic [ALN_W-1:0] sig;
    logic [ALN_W-1:0] aligned;
    logic             is_nan;
    logic [RES_W-1:0] mag;
    logic             carry;
    logic             frac_nz;
    logic             bump;
    logic             neg_big;
    logic             too_big;
    logic [RES_W-1:0] res_d;
    logic             inv_d;
    logic             inx_d;
    slot_e            state_q;
    slot_e            state_d;

    assign op       = quad_t'(operand);
    assign eff_mode = trunc_force ? RM_TO_ZERO : rmode_e'(round_mode);
    assign neg_big  = op.sign && (op.exp > EXP_W'(NEG_EXP));
    assign too_big  = op.exp > EXP_W'(SAT_EXP);

    q2u_unpack u_unpack (
        .exp_i    (op.exp),
        .frac_i   (op.frac),
        .sig_o    (sig),
        .is_nan_o (is_nan)
    );

    q2u_align u_align (
        .exp_i     (op.exp),
        .sig_i     (sig),
        .aligned_o (aligned)
    );

    q2u_round u_round (
        .sign_i    (op.sign),
        .aligned_i (aligned),
        .mode_i    (eff_mode),
        .mag_o     (mag),
        .carry_o   (carry),
        .frac_nz_o (frac_nz),
        .bump_o    (bump)
    );

    always_comb begin
        if (neg_big) begin
            res_d = is_nan ? '1 : '0;
            inv_d = 1'b1;
            inx_d = 1'b0;
        end else if (too_big) begin
            res_d = '1;
            inv_d = 1'b1;
            inx_d = 1'b0;
        end else if (op.sign) begin
            res_d = '0;
            inv_d = 1'b0;
            inx_d = bump;
        end else if (carry) begin
            res_d = '1;
            inv_d = 1'b1;
            inx_d = 1'b0;
        end else begin
            res_d = mag;
            inv_d = 1'b0;
            inx_d = frac_nz;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else if (in_valid) begin
            result       <= res_d;
            flag_invalid <= inv_d;
            flag_inexact <= inx_d;
        end
    end

    assign out_valid = (state_q == ST_FULL);

    // R1
    load_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    drain_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(flag_invalid && flag_inexact));

    // R7
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |-> ((result == '1) || (result == '0)));

    // R9
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand[OP_W-1] && !((&operand[OP_W-2:FRAC_W]) && (|operand[FRAC_W-1:0])))
        |=> (result == '0));

    // R10
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (operand[OP_W-2:0] == '0))
        |=> ((result == '0) && !flag_invalid && !flag_inexact));

    // R5
    trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && trunc_force && !operand[OP_W-1] && (operand[OP_W-2:FRAC_W] <= EXP_W'(SAT_EXP)))
        |=> !flag_invalid);
endmodule

// File: tb/test_q2u_convert.sv
`timescale 1ns/1ps
module test_q2u_convert;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] operand = '0;
    logic [1:0]   round_mode = 2'b00;
    logic         trunc_force = 1'b0;
    logic         out_valid;
    logic [63:0]  result;
    logic         flag_invalid;
    logic         flag_inexact;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        inv;
        logic        inx;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t got;

    always #2 clk = ~clk;

    q2u_convert i_q2u_convert (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .operand      (operand),
        .round_mode   (round_mode),
        .trunc_force  (trunc_force),
        .out_valid    (out_valid),
        .result       (result),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact)
    );

    function automatic logic [127:0] mk(input logic s, input int e, input logic [111:0] f);
        return {s, 15'(e), f};
    endfunction

    // wide fixed-point model: 64 integer bits over 128 fraction bits
    function automatic logic [65:0] ref_conv(input logic [127:0] op, input logic [1:0] md);
        logic         s;
        logic [14:0]  e;
        logic [111:0] f;
        logic [191:0] sx;
        logic [191:0] x;
        logic [63:0]  ip;
        logic [127:0] fr;
        logic [63:0]  ones;
        int           unb;
        int           sh;
        logic         sticky;
        logic         nz;
        logic         gt;
        logic         eq;
        logic         inc;
        s = op[127];
        e = op[126:112];
        f = op[111:0];
        ones = '1;
        if (e == 15'h7FFF) begin
            if (f != 0) return {ones, 2'b10};
            return s ? {64'd0, 2'b10} : {ones, 2'b10};
        end
        if (e == 0 && f == 0) return '0;
        unb = (e == 0) ? -16382 : int'(e) - 16383;
        if (unb >= 0 && s) return {64'd0, 2'b10};
        if (unb >= 64) return {ones, 2'b10};
        sx = {79'd0, (e != 0), f};
        sh = unb + 16;
        sticky = 1'b0;
        if (sh >= 0) begin
            x = sx << sh;
        end else if (sh > -192) begin
            x = sx >> (-sh);
            sticky = ((x << (-sh)) != sx);
        end else begin
            x = '0;
            sticky = 1'b1;
        end
        ip = x[191:128];
        fr = x[127:0];
        nz = (fr != 0) || sticky;
        gt = fr[127] && ((fr[126:0] != 0) || sticky);
        eq = fr[127] && (fr[126:0] == 0) && !sticky;
        case (md)
            2'b00:   inc = gt || (eq && ip[0]);
            2'b01:   inc = 1'b0;
            2'b10:   inc = !s && nz;
            default: inc = s && nz;
        endcase
        if (s) return {64'd0, 1'b0, inc};
        if (inc && ip == ones) return {ones, 2'b10};
        return {ip + 64'(inc), 1'b0, nz};
    endfunction

    task automatic drive(input logic [127:0] op, input logic [1:0] md, input logic rz, input string tag);
        exp_t        it;
        logic [65:0] r;
        r = ref_conv(op, rz ? 2'b01 : md);
        it.res = r[65:2];
        it.inv = r[1];
        it.inx = r[0];
        it.tag = tag;
        in_valid    = 1'b1;
        operand     = op;
        round_mode  = md;
        trunc_force = rz;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid    = 1'b0;
        trunc_force = 1'b0;
        @(negedge clk);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: pair each fresh result with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected result: actual valid=1 expected valid=0");
            end else begin
                got = q.pop_front();
                if (result !== got.res || flag_invalid !== got.inv || flag_inexact !== got.inx) begin
                    errors++;
                    $display("FAIL %s: actual res=%h inv=%b inx=%b expected res=%h inv=%b inx=%b",
                             got.tag, result, flag_invalid, flag_inexact, got.res, got.inv, got.inx);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            done = 1'b1;
            report();
        end
    end

    initial begin
        in_valid = 1'b1;
        operand  = mk(0, 16383, '0);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: actual v=%b res=%h expected v=0 res=0", out_valid, result);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0) begin
            errors++;
            $display("FAIL R1 after reset: actual v=%b res=%h expected v=0 res=0", out_valid, result);
        end

        drive(mk(0, 16383, '0), 2'b00, 0, "R2 one");
        drive(mk(0, 16383 + 62, 112'(1) << 50), 2'b00, 0, "R2 2^62+1");
        drive(mk(0, 16383 + 63, {{63{1'b1}}, 49'd0}), 2'b11, 0, "R2 2^64-1");
        idle();
        drive(mk(0, 16384, 112'(1) << 110), 2'b00, 0, "R3 2.5 nearest");
        drive(mk(0, 16384, 112'(3) << 110), 2'b00, 0, "R3 3.5 nearest");
        drive(mk(0, 16383, 112'(1) << 111), 2'b00, 0, "R3 1.5 nearest");
        drive(mk(0, 16384, 112'(1) << 110), 2'b01, 0, "R3 2.5 to zero");
        drive(mk(0, 16384, 112'(1) << 110), 2'b10, 0, "R3 2.5 to pos");
        drive(mk(0, 16384, 112'(1) << 110), 2'b11, 0, "R3 2.5 to neg");
        drive(mk(0, 16384, 112'(3) << 109), 2'b00, 0, "R4 2.75 nearest");
        drive(mk(0, 16382, '0), 2'b00, 0, "R4 0.5 nearest");
        drive(mk(0, 16384, 112'(1) << 110), 2'b10, 1, "R5 2.5 forced trunc");
        drive(mk(0, 16384, 112'(1) << 110), 2'b10, 0, "R5 mode kept after force");
        drive(mk(0, 16383 + 63, {{64{1'b1}}, 48'd0}), 2'b00, 0, "R6 2^64-0.5 nearest carry");
        drive(mk(0, 16383 + 63, {{64{1'b1}}, 48'd0}), 2'b01, 0, "R6 2^64-0.5 to zero");
        drive(mk(0, 16383 + 63, {{64{1'b1}}, 48'd0}), 2'b00, 1, "R5 2^64-0.5 forced trunc");
        drive(mk(0, 16383 + 63, {{64{1'b1}}, 48'd0}), 2'b10, 0, "R6 2^64-0.5 to pos");
        idle();
        drive(mk(0, 16383 + 64, '0), 2'b00, 0, "R7 2^64");
        drive(mk(0, 32767, '0), 2'b00, 0, "R7 +inf");
        drive(mk(0, 32767, 112'(1) << 111), 2'b00, 0, "R7 +NaN");
        drive(mk(1, 32767, 112'(1) << 111), 2'b00, 0, "R7 -NaN");
        drive(mk(1, 16383, '0), 2'b00, 0, "R8 -1.0");
        drive(mk(1, 32767, '0), 2'b00, 0, "R8 -inf");
        drive(mk(1, 16382, 112'(1) << 111), 2'b00, 0, "R9 -0.75 nearest");
        drive(mk(1, 16381, '0), 2'b00, 0, "R9 -0.25 nearest");
        drive(mk(1, 16381, '0), 2'b11, 0, "R9 -0.25 to neg");
        drive(mk(1, 16382, '0), 2'b00, 0, "R9 -0.5 nearest");
        drive(mk(1, 16382, 112'(1) << 111), 2'b11, 1, "R9 -0.75 forced trunc");
        drive(mk(0, 0, '0), 2'b10, 0, "R10 +zero");
        drive(mk(1, 0, '0), 2'b11, 0, "R10 -zero");
        drive(mk(0, 0, 112'(1)), 2'b00, 0, "R10 subnormal nearest");
        drive(mk(0, 0, 112'(1)), 2'b10, 0, "R10 subnormal to pos");
        drive(mk(0, 16384, (112'(1) << 110) | 112'(1)), 2'b00, 0, "R11 2.5+tiny nearest");
        drive(mk(0, 16383 - 100, '0), 2'b10, 0, "R11 far-right tiny to pos");
        drive(mk(0, 16383 - 100, '0), 2'b00, 0, "R11 far-right tiny nearest");

        idle();
        idle();
        checks++;
        if (out_valid !== 1'b0 || q.size() != 0) begin
            errors++;
            $display("FAIL R1 drain: actual v=%b pending=%0d expected v=0 pending=0", out_valid, q.size());
        end
        done = 1'b1;
        report();
    end
endmodule